// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table out of memory. The upper ten address bits pick a word in a page-sized directory whose location comes from a base input that software reloads on every process switch. That word names a second-level table. The middle ten bits pick a word in that table, which supplies the frame number. The low twelve bits are copied straight through as the byte offset within the page.

A requester presents an address and an access kind (read, write or execute, plus the current privilege) with a valid/ready handshake. The walker then issues at most two word reads on a single-outstanding memory port and ends the walk with a one-cycle done pulse that carries the physical address and a fault code. A directory length input bounds the first-level index. Each entry has a valid bit, and the final entry carries access permissions. A parameter enables directory entries that map a whole 4 MB region directly. It is off by default.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and after it is released, `req_ready` is 1 and `mem_rd_valid`, `rsp_done`, `rsp_fault` and `rsp_paddr` are all 0.
- R2: The first read of a walk goes to address `{dir_base[31:12], vaddr[31:22], 2'b00}`. The second read goes to `{dir_entry[31:12], vaddr[21:12], 2'b00}`.
- R3: When neither level faults, the walk makes exactly two reads. It reports fault code 0 with `rsp_paddr = {table_entry[31:12], vaddr[11:0]}`.
- R4: If `{1'b0, vaddr[31:22]}` is greater than or equal to the `dir_len` value sampled at acceptance, the walk reports fault code 2 and makes no memory read.
- R5: An entry whose bit 0 (valid) is 0 ends the walk with fault code 1. An invalid directory entry ends the walk after one read, and an invalid table entry ends it after two reads.
- R6: The table entry's permission bits are bit 1 read, bit 2 write, bit 3 execute and bit 4 kernel-only. Fault code 3 is reported when any of these holds: a plain read (write=0, execute=0) finds bit 1 clear; a write finds bit 2 clear; an execute finds bit 3 clear; or bit 4 is set while `req_priv` is 0.
- R7: `req_ready` is high only when the walker is idle. The address, access kind, `dir_base` and `dir_len` are captured at acceptance, so later changes to them do not affect a walk in progress.
- R8: `mem_rd_valid` stays high with a stable `mem_rd_addr` until the cycle in which `mem_ack` is high. `mem_rd_data` is used only in that cycle.
- R9: `rsp_done` is a single-cycle pulse. `rsp_paddr` and `rsp_fault` are valid while it is high, and `rsp_paddr` is 0 whenever the fault code is non-zero.
- R10: With the default `LARGE_PAGE_EN = 0`, bit 7 of a directory entry is ignored, so every non-faulting walk still performs both reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_exec | input | 1 | Access is an instruction fetch |
| req_priv | input | 1 | Requester runs in kernel mode |
| dir_base | input | 32 | Directory base address (bits 11:0 unused) |
| dir_len | input | 11 | Number of directory entries in use (0 to 1024) |
| mem_rd_valid | output | 1 | Word read request |
| mem_rd_addr | output | 32 | Byte address of the word read |
| mem_ack | input | 1 | Read completes; data present this cycle |
| mem_rd_data | input | 32 | Read data |
| rsp_done | output | 1 | Walk finished (one-cycle pulse) |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_fault | output | 2 | 0 none, 1 invalid entry, 2 length, 3 protection |

## Verification
The properties rely on three conditions on the environment. The memory side raises `mem_ack` only while `mem_rd_valid` is high, and it presents data in that same cycle. The requester offers a new request only when the walker is idle. `dir_base` is page aligned. The bench's memory model acknowledges only pending reads, after a latency of zero to two cycles, and drives a junk pattern on the data lines outside acknowledged cycles. The sequencing issues each request from idle and then scrambles the address, the base and the length lines during the walk. Expected translations come from an arithmetic table model that is swept across directory indices on both sides of the length bound, over every combination of table permission bits, and over all three access kinds in both privilege modes.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_LENGTH  = 2'd2,
    FLT_PROT    = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIR  = 2'd1,
    ST_TBL  = 2'd2,
    ST_RESP = 2'd3
  } walk_st_e;

  // entry flag positions
  localparam int unsigned ENT_V  = 0;
  localparam int unsigned ENT_R  = 1;
  localparam int unsigned ENT_W  = 2;
  localparam int unsigned ENT_X  = 3;
  localparam int unsigned ENT_K  = 4;
  localparam int unsigned ENT_LG = 7;

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12,
  localparam int unsigned PG_W  = ADDR_W - OFF_W,
  localparam int unsigned PAD_W = OFF_W - IDX_W
) (
  input  logic [PG_W-1:0]   page,
  input  logic [IDX_W-1:0]  index,
  output logic [ADDR_W-1:0] addr
);

  // word-sized entries packed into one page
  assign addr = {page, index, {PAD_W{1'b0}}};

endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check
  import pt_walker_pkg::*;
(
  input  logic [7:0] flags,
  input  logic       acc_write,
  input  logic       acc_exec,
  input  logic       acc_priv,
  output logic       violation
);

  logic rd_bad, wr_bad, ex_bad, pv_bad;

  always_comb begin
    rd_bad    = !acc_write && !acc_exec && !flags[ENT_R];
    wr_bad    = acc_write && !flags[ENT_W];
    ex_bad    = acc_exec && !flags[ENT_X];
    pv_bad    = flags[ENT_K] && !acc_priv;
    violation = rd_bad || wr_bad || ex_bad || pv_bad;
  end

endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walker_pkg::*;
#(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned DIR_IDX_W     = 10,
  parameter int unsigned TBL_IDX_W     = 10,
  parameter int unsigned OFF_W         = 12,
  parameter bit          LARGE_PAGE_EN = 1'b0,
  localparam int unsigned PG_W         = ADDR_W - OFF_W,
  localparam int unsigned LEN_W        = DIR_IDX_W + 1,
  localparam int unsigned LG_LO        = TBL_IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic              req_exec,
  input  logic              req_priv,
  input  logic [PG_W-1:0]   base_pg_in,
  input  logic [LEN_W-1:0]  dir_len,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rd_data,
  input  logic              perm_fail,
  output logic              req_ready,
  output logic              mem_rd_valid,
  output logic              sel_tbl,
  output logic [PG_W-1:0]   base_pg_q,
  output logic [PG_W-1:0]   tbl_pg_q,
  output logic [ADDR_W-1:0] va_q,
  output logic              acc_wr_q,
  output logic              acc_ex_q,
  output logic              acc_pv_q,
  output logic              rsp_done,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [1:0]        rsp_fault
);

  walk_st_e          state_q, state_d;
  logic              cap_en, tbl_ld, rsp_ld;
  logic [ADDR_W-1:0] paddr_q, paddr_d;
  fault_e            fault_q, fault_d;
  logic              len_fault;
  logic              lg_hit;
  logic [ADDR_W-1:0] lg_pa, sm_pa;
  logic              unused_entry;

  assign unused_entry = ^mem_rd_data;

  generate
    if (LARGE_PAGE_EN) begin : g_large
      assign lg_hit = mem_rd_data[ENT_LG];
    end else begin : g_small
      assign lg_hit = 1'b0;
    end
  endgenerate

  assign len_fault = {1'b0, req_vaddr[ADDR_W-1 -: DIR_IDX_W]} >= dir_len;
  assign lg_pa     = {mem_rd_data[ADDR_W-1:LG_LO], va_q[LG_LO-1:0]};
  assign sm_pa     = {mem_rd_data[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]};

  // next-state
  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    tbl_ld  = 1'b0;
    rsp_ld  = 1'b0;
    paddr_d = '0;
    fault_d = FLT_NONE;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_en = 1'b1;
          if (len_fault) begin
            state_d = ST_RESP;
            rsp_ld  = 1'b1;
            fault_d = FLT_LENGTH;
          end else begin
            state_d = ST_DIR;
          end
        end
      end
      ST_DIR: begin
        if (mem_ack) begin
          if (!mem_rd_data[ENT_V]) begin
            state_d = ST_RESP;
            rsp_ld  = 1'b1;
            fault_d = FLT_INVALID;
          end else if (lg_hit) begin
            state_d = ST_RESP;
            rsp_ld  = 1'b1;
            if (perm_fail) fault_d = FLT_PROT;
            else           paddr_d = lg_pa;
          end else begin
            tbl_ld  = 1'b1;
            state_d = ST_TBL;
          end
        end
      end
      ST_TBL: begin
        if (mem_ack) begin
          state_d = ST_RESP;
          rsp_ld  = 1'b1;
          if (!mem_rd_data[ENT_V]) fault_d = FLT_INVALID;
          else if (perm_fail)      fault_d = FLT_PROT;
          else                     paddr_d = sm_pa;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q      <= '0;
      acc_wr_q  <= 1'b0;
      acc_ex_q  <= 1'b0;
      acc_pv_q  <= 1'b0;
      base_pg_q <= '0;
    end else if (cap_en) begin
      va_q      <= req_vaddr;
      acc_wr_q  <= req_write;
      acc_ex_q  <= req_exec;
      acc_pv_q  <= req_priv;
      base_pg_q <= base_pg_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tbl_pg_q <= '0;
    else if (tbl_ld) tbl_pg_q <= mem_rd_data[ADDR_W-1:OFF_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr_q <= '0;
      fault_q <= FLT_NONE;
    end else if (rsp_ld) begin
      paddr_q <= paddr_d;
      fault_q <= fault_d;
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign mem_rd_valid = (state_q == ST_DIR) || (state_q == ST_TBL);
  assign sel_tbl      = (state_q == ST_TBL);
  assign rsp_done     = (state_q == ST_RESP);
  assign rsp_paddr    = paddr_q;
  assign rsp_fault    = fault_q;

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned DIR_IDX_W     = 10,
  parameter int unsigned TBL_IDX_W     = 10,
  parameter int unsigned OFF_W         = 12,
  parameter bit          LARGE_PAGE_EN = 1'b0,
  localparam int unsigned PG_W         = ADDR_W - OFF_W,
  localparam int unsigned LEN_W        = DIR_IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic              req_exec,
  input  logic              req_priv,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic [LEN_W-1:0]  dir_len,
  output logic              mem_rd_valid,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rd_data,
  output logic              rsp_done,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [1:0]        rsp_fault
);

  logic              sel_tbl, perm_fail;
  logic              acc_wr_q, acc_ex_q, acc_pv_q;
  logic [PG_W-1:0]   base_pg_q, tbl_pg_q;
  logic [ADDR_W-1:0] va_q, dir_addr, tbl_addr;
  logic [OFF_W-1:0]  unused_base_lo;

  assign unused_base_lo = dir_base[OFF_W-1:0];

  pt_walk_ctrl #(
    .ADDR_W(ADDR_W), .DIR_IDX_W(DIR_IDX_W), .TBL_IDX_W(TBL_IDX_W),
    .OFF_W(OFF_W), .LARGE_PAGE_EN(LARGE_PAGE_EN)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_vaddr    (req_vaddr),
    .req_write    (req_write),
    .req_exec     (req_exec),
    .req_priv     (req_priv),
    .base_pg_in   (dir_base[ADDR_W-1:OFF_W]),
    .dir_len      (dir_len),
    .mem_ack      (mem_ack),
    .mem_rd_data  (mem_rd_data),
    .perm_fail    (perm_fail),
    .req_ready    (req_ready),
    .mem_rd_valid (mem_rd_valid),
    .sel_tbl      (sel_tbl),
    .base_pg_q    (base_pg_q),
    .tbl_pg_q     (tbl_pg_q),
    .va_q         (va_q),
    .acc_wr_q     (acc_wr_q),
    .acc_ex_q     (acc_ex_q),
    .acc_pv_q     (acc_pv_q),
    .rsp_done     (rsp_done),
    .rsp_paddr    (rsp_paddr),
    .rsp_fault    (rsp_fault)
  );

  pt_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(DIR_IDX_W), .OFF_W(OFF_W)) u_dir_addr (
    .page  (base_pg_q),
    .index (va_q[ADDR_W-1 -: DIR_IDX_W]),
    .addr  (dir_addr)
  );

  pt_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(TBL_IDX_W), .OFF_W(OFF_W)) u_tbl_addr (
    .page  (tbl_pg_q),
    .index (va_q[OFF_W +: TBL_IDX_W]),
    .addr  (tbl_addr)
  );

  pt_perm_check u_perm (
    .flags     (mem_rd_data[7:0]),
    .acc_write (acc_wr_q),
    .acc_exec  (acc_ex_q),
    .acc_priv  (acc_pv_q),
    .violation (perm_fail)
  );

  assign mem_rd_addr = sel_tbl ? tbl_addr : dir_addr;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned DIR_IDX_W     = 10,
  parameter int unsigned OFF_W         = 12,
  parameter bit          LARGE_PAGE_EN = 1'b0,
  localparam int unsigned LEN_W        = DIR_IDX_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic [LEN_W-1:0]  dir_len,
  input logic              mem_rd_valid,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_ack,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [1:0]        rsp_fault
);

  logic [OFF_W-1:0] off_q;
  logic [1:0]       rd_q;
  logic             unused_va;

  assign unused_va = ^req_vaddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      rd_q  <= '0;
    end else if (req_valid && req_ready) begin
      off_q <= req_vaddr[OFF_W-1:0];
      rd_q  <= '0;
    end else if (mem_rd_valid && mem_ack && rd_q != 2'd3) begin
      rd_q  <= rd_q + 2'd1;
    end
  end

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_ack |=> mem_rd_valid && $stable(mem_rd_addr));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R9
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && rsp_fault != 2'd0 |-> rsp_paddr == '0);

  // R4
  len_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && ({1'b0, req_vaddr[ADDR_W-1 -: DIR_IDX_W]} >= dir_len)
    |=> rsp_done && rsp_fault == 2'd2);

  // R4
  len_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && rsp_fault == 2'd2 |-> rd_q == 2'd0);

  // R7
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid || rsp_done) |-> !req_ready);

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && rsp_fault == 2'd0 |-> rsp_paddr[OFF_W-1:0] == off_q);

  // R3 R10
  two_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && rsp_fault == 2'd0 && !LARGE_PAGE_EN |-> rd_q == 2'd2);

  // R5
  invalid_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && rsp_fault == 2'd1 |-> rd_q != 2'd0);

endmodule

bind pt_walker pt_walker_chk #(
  .ADDR_W(ADDR_W), .DIR_IDX_W(DIR_IDX_W), .OFF_W(OFF_W), .LARGE_PAGE_EN(LARGE_PAGE_EN)
) u_chk (.*);

// File: tb/pt_walker_test.sv
module pt_walker_test;

  localparam logic [19:0] BASE_A = 20'h00040;
  localparam logic [19:0] BASE_B = 20'h00080;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_exec, req_priv;
  logic [31:0] req_vaddr, dir_base;
  logic [10:0] dir_len;
  logic        mem_rd_valid, mem_ack;
  logic [31:0] mem_rd_addr, mem_rd_data;
  logic        rsp_done;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int n_cmp = 0;
  int n_bad = 0;
  int rd_count = 0;
  int lat = 0;
  int wait_cnt = 0;
  logic [31:0] held_addr;
  logic [31:0] rd_log [2];

  always #5 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_exec(req_exec),
    .req_priv(req_priv), .dir_base(dir_base), .dir_len(dir_len),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_ack(mem_ack),
    .mem_rd_data(mem_rd_data), .rsp_done(rsp_done), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // table contents computed from the address
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [19:0] pg;
    logic [9:0]  ix;
    logic [31:0] w;
    pg = a[31:12];
    ix = a[11:2];
    w  = '0;
    if (pg == BASE_A || pg == BASE_B) begin
      w[31:12] = (pg == BASE_A) ? (20'h00100 + {10'd0, ix}) : (20'h00300 + {10'd0, ix});
      w[0]     = (int'(ix) % 5) != 3;
      w[7]     = ix[0];
    end else begin
      w[31:12] = 20'(pg * 20'd37) ^ {10'd0, ix} ^ 20'h5A000;
      w[0]     = (int'(ix) % 7) != 6;
      w[4:1]   = 4'(ix[3:0] + pg[3:0]);
      w[7]     = ix[1];
    end
    return w;
  endfunction

  task automatic model(input logic [31:0] va, input bit wr, input bit ex, input bit pv,
                       input logic [19:0] bpg, input logic [10:0] len,
                       output logic [31:0] pa, output logic [1:0] flt, output int nrd,
                       output logic [31:0] de);
    logic [31:0] te;
    bit viol;
    pa = '0; flt = 2'd0; nrd = 0; de = '0;
    if ({1'b0, va[31:22]} >= len) begin flt = 2'd2; return; end
    de = mem_word({bpg, va[31:22], 2'b00});
    nrd = 1;
    if (!de[0]) begin flt = 2'd1; return; end
    te = mem_word({de[31:12], va[21:12], 2'b00});
    nrd = 2;
    if (!te[0]) begin flt = 2'd1; return; end
    viol = (!wr && !ex && !te[1]) || (wr && !te[2]) || (ex && !te[3]) || (te[4] && !pv);
    if (viol) begin flt = 2'd3; return; end
    pa = {te[31:12], va[11:0]};
  endtask

  // memory responder
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      mem_rd_data = 32'hDEAD_BEEF;
      wait_cnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
      mem_rd_data = 32'hDEAD_BEEF;
      wait_cnt = 0;
    end else if (mem_rd_valid) begin
      if (wait_cnt == 0) held_addr = mem_rd_addr;
      if (wait_cnt >= lat) begin
        chk(mem_rd_addr == held_addr, "R8 address held until ack", mem_rd_addr, held_addr);
        mem_ack = 1'b1;
        mem_rd_data = mem_word(mem_rd_addr);
        if (rd_count < 2) rd_log[rd_count] = mem_rd_addr;
        rd_count++;
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input bit wr, input bit ex, input bit pv, input bit swap);
    logic [31:0] epa, de, obase;
    logic [1:0]  ef;
    logic [10:0] olen;
    int enr;
    int cyc;
    string tag;
    obase = dir_base;
    olen  = dir_len;
    model(va, wr, ex, pv, dir_base[31:12], dir_len, epa, ef, enr, de);
    case (ef)
      2'd0: tag = "R3";
      2'd1: tag = "R5";
      2'd2: tag = "R4";
      default: tag = "R6";
    endcase
    rd_count = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_exec = ex; req_priv = pv;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_vaddr = ~va; req_write = ~wr; req_exec = ~ex; req_priv = ~pv;
    chk(req_ready == 1'b0, "R7 ready low during walk", {31'd0, req_ready}, 32'd0);
    if (swap) begin dir_base = {BASE_B, 12'h0}; dir_len = 11'd0; end
    cyc = 0;
    while (!rsp_done && cyc < 64) begin @(negedge clk); cyc++; end
    chk(rsp_done == 1'b1, "R9 done pulse seen", {31'd0, rsp_done}, 32'd1);
    chk(rsp_fault == ef, {tag, " fault code"}, {30'd0, rsp_fault}, {30'd0, ef});
    chk(rsp_paddr == epa, {tag, " physical address"}, rsp_paddr, epa);
    chk(rd_count == enr, {tag, " read count"}, rd_count, enr);
    if (enr >= 1)
      chk(rd_log[0] == {obase[31:12], va[31:22], 2'b00}, "R2 directory read address",
          rd_log[0], {obase[31:12], va[31:22], 2'b00});
    if (enr == 2)
      chk(rd_log[1] == {de[31:12], va[21:12], 2'b00}, "R2 table read address",
          rd_log[1], {de[31:12], va[21:12], 2'b00});
    if (enr >= 1 && de[0] && de[7])
      chk(rd_count == 2, "R10 large-page bit ignored", rd_count, 2);
    @(negedge clk);
    chk(rsp_done == 1'b0, "R9 done lasts one cycle", {31'd0, rsp_done}, 32'd0);
    chk(req_ready == 1'b1, "R7 ready after walk", {31'd0, req_ready}, 32'd1);
    if (swap) begin dir_base = obase; dir_len = olen; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int nwalk;
    rst_n = 1'b0;
    req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; req_exec = 1'b0; req_priv = 1'b0;
    dir_base = {BASE_A, 12'h0};
    dir_len = 11'd12;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(req_ready == 1'b1, "R1 ready in reset", {31'd0, req_ready}, 32'd1);
    chk(mem_rd_valid == 1'b0, "R1 no read in reset", {31'd0, mem_rd_valid}, 32'd0);
    chk(rsp_done == 1'b0, "R1 no done in reset", {31'd0, rsp_done}, 32'd0);
    chk(rsp_fault == 2'd0 && rsp_paddr == 32'd0, "R1 response cleared", rsp_paddr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_rd_valid == 1'b0 && rsp_done == 1'b0,
        "R1 idle after reset", {29'd0, req_ready, mem_rd_valid, rsp_done}, 32'd4);

    nwalk = 0;
    for (int d = 0; d < 14; d++) begin
      for (int j = 0; j < 18; j++) begin
        for (int acc = 0; acc < 3; acc++) begin
          for (int pv = 0; pv < 2; pv++) begin
            logic [9:0]  i2;
            logic [11:0] off;
            i2  = (j < 16) ? 10'(j) : 10'(1006 + j);
            off = 12'(d * 291 + j * 53 + acc * 7 + pv);
            lat = nwalk % 3;
            walk({10'(d), i2, off}, acc == 1, acc == 2, pv == 1, 1'b0);
            nwalk++;
          end
        end
      end
    end

    // R4 length boundaries
    dir_len = 11'd1024;
    walk({10'd1023, 10'd5, 12'h123}, 1'b0, 1'b0, 1'b1, 1'b0);
    walk({10'd1022, 10'd2, 12'hABC}, 1'b0, 1'b0, 1'b1, 1'b0);
    dir_len = 11'd0;
    walk({10'd0, 10'd2, 12'h001}, 1'b0, 1'b0, 1'b1, 1'b0);
    // R7 base and length changed mid-walk
    dir_len = 11'd12;
    lat = 2;
    walk({10'd2, 10'd4, 12'h777}, 1'b0, 1'b0, 1'b1, 1'b1);
    walk({10'd0, 10'd9, 12'h0F0}, 1'b1, 1'b0, 1'b1, 1'b1);

    summary();
    $finish;
  end

endmodule